// File: doc/BRIEF.md
# Sequential Signed Add-Shift Multiplier

This block multiplies two N-bit two's-complement operands over N clock cycles and returns a 2N-bit signed product. It is split into a small controller and a datapath. The datapath holds the multiplicand, a combined upper/lower product register, an (N+1)-bit adder with a complementer in front of it, and an iteration counter.

On each iteration the block looks at the low bit of the lower half. When that bit is 1, the multiplicand is added into the upper half. The adder result is written back one position lower in the same cycle, so a separate shift step is not needed. The multiplier's sign bit carries negative weight, so the final iteration subtracts the multiplicand instead of adding it. The counter tells the controller when the last iteration is under way.

To use the block, present the operands with a one-cycle start strobe while the block is idle. Then wait for `done`. The product stays on the output until the next start is accepted.

Top module: `mul_signed_seq`

## Requirements
- R1: An active-high synchronous reset clears `done` and the product to zero and returns the controller to idle. A reset in mid-operation abandons it, and no completion follows.
- R2: A start strobe sampled while idle loads the operands, and `done` reads 0 from the next cycle on.
- R3: After the clock edge that accepts start, exactly N further edges complete the operation. `done` is still 0 after edge N-1 and is 1 after edge N.
- R4: The product equals the signed product of X and Y, interpreted as a 2N-bit two's-complement value, for operands of any sign.
- R5: Corner operands give exact results: the most negative value squared, -1 times -1, and the largest positive value times the most negative value.
- R6: When the multiplier is negative, its top bit is weighted -2^(N-1). The final iteration therefore subtracts the multiplicand, adding its complement with a carry-in of 1.
- R7: After completion, `done` and the product hold their values while no start arrives, even if the operand inputs change.
- R8: Start strobes and operand changes during an operation are ignored. The result is the product of the operands captured at the accepted start.
- R9: The iteration counter never exceeds N-1, advances by one per iteration, and flags the last iteration to the controller.
- R10: The width N is a parameter. The block gives exact results at N = 32 as well as at narrow widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; accepted only while idle |
| x_in | input | N | Multiplier, two's complement |
| y_in | input | N | Multiplicand, two's complement |
| product | output | 2N | Signed product, valid while `done` is 1 |
| done | output | 1 | High once an operation completes, until the next start is accepted |

## Verification
On every cycle, the assertions check several behaviours:
- the reset outcome;
- operand capture on an accepted start;
- the counter's single-step advance and its upper bound;
- the return to idle with `done` raised after the last iteration;
- that a start strobe arriving mid-run does not disturb the run;
- that the product holds steady while done and idle.

Arithmetic correctness, including the sign-bit subtraction and the extreme operands at 8 and 32 bits, can only be shown by the bench's operand scenarios. The same is true of the exact completion latency and of an abandoned run after a mid-operation reset.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    // command from controller to datapath
    typedef struct packed {
        logic load;   // capture operands, clear upper half and counter
        logic step;   // one add-and-shift iteration
    } dp_cmd_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mul_seq_counter.sv
module mul_seq_counter
    import mul_seq_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic last
);
    localparam int unsigned CW = cnt_width(N);
    localparam logic [CW-1:0] LAST_VAL = CW'(N - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (advance) begin
            cnt_d = (cnt_q == LAST_VAL) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q == LAST_VAL);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_VAL);

endmodule

// File: rtl/mul_seq_dp.sv
module mul_seq_dp
    import mul_seq_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  dp_cmd_t         cmd,
    input  logic [N-1:0]    x_in,
    input  logic [N-1:0]    y_in,
    output logic            last,
    output logic [2*N-1:0]  product
);
    localparam int unsigned EW = N + 1;

    logic [N-1:0]  upper_q, upper_d;   // accumulator half
    logic [N-1:0]  lower_q, lower_d;   // multiplier half
    logic [N-1:0]  mcand_q, mcand_d;
    logic [EW-1:0] mcand_ext;
    logic [EW-1:0] addend;
    logic [EW-1:0] carry_in;
    logic [EW-1:0] sum;

    mul_seq_counter #(.N(N)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .clear   (cmd.load),
        .advance (cmd.step),
        .last    (last)
    );

    // complementer and sign-extended adder
    always_comb begin
        mcand_ext = {mcand_q[N-1], mcand_q};
        addend    = '0;
        carry_in  = '0;
        if (lower_q[0]) begin
            if (last) begin
                addend   = ~mcand_ext;
                carry_in = EW'(1);
            end else begin
                addend   = mcand_ext;
            end
        end
        sum = {upper_q[N-1], upper_q} + addend + carry_in;
    end

    // next-state for the register halves: shift happens by wiring
    always_comb begin
        upper_d = upper_q;
        lower_d = lower_q;
        mcand_d = mcand_q;
        if (cmd.load) begin
            upper_d = '0;
            lower_d = x_in;
            mcand_d = y_in;
        end else if (cmd.step) begin
            upper_d = sum[EW-1:1];
            lower_d = {sum[0], lower_q[N-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            lower_q <= '0;
            mcand_q <= '0;
        end else begin
            upper_q <= upper_d;
            lower_q <= lower_d;
            mcand_q <= mcand_d;
        end
    end

    assign product = {upper_q, lower_q};

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (upper_q == '0 && lower_q == $past(x_in) && mcand_q == $past(y_in)));

    assert_mcand_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && !cmd.load) |=> $stable(mcand_q));

endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
    import mul_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    last,
    output dp_cmd_t cmd,
    output logic    done
);
    ctl_state_e state_q, state_d;
    logic       done_d;

    always_comb begin
        state_d  = state_q;
        done_d   = done;
        cmd.load = 1'b0;
        cmd.step = 1'b0;
        unique case (state_q)
            CTL_IDLE: begin
                if (start) begin
                    cmd.load = 1'b1;
                    done_d   = 1'b0;
                    state_d  = CTL_RUN;
                end
            end
            CTL_RUN: begin
                cmd.step = 1'b1;
                if (last) begin
                    done_d  = 1'b1;
                    state_d = CTL_IDLE;
                end
            end
            default: state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= done_d;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!done && state_q == CTL_IDLE));

    assert_finish_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && last) |=> (done && state_q == CTL_IDLE));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_q == CTL_IDLE));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTL_RUN && !last && start) |=> (state_q == CTL_RUN && !done));

endmodule

// File: rtl/mul_signed_seq.sv
module mul_signed_seq
    import mul_seq_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   x_in,
    input  logic [N-1:0]   y_in,
    output logic [2*N-1:0] product,
    output logic           done
);
    dp_cmd_t cmd;
    logic    last;

    mul_seq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (last),
        .cmd   (cmd),
        .done  (done)
    );

    mul_seq_dp #(.N(N)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .x_in    (x_in),
        .y_in    (y_in),
        .last    (last),
        .product (product)
    );

    assert_product_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(product) && done));

endmodule

// File: tb/mul_signed_seq_bench.sv
module mul_signed_seq_bench;
    localparam int NA = 8;
    localparam int NB = 32;
    localparam int NV = 14;

    localparam logic [NA-1:0] VX [NV] = '{8'sd3, -8'sd3, 8'sd3, -8'sd3, 8'sd0, -8'sd128, -8'sd1,
                                         8'sd127, 8'sd127, -8'sd128, 8'sd16, -8'sd16, 8'sd16, -8'sd16};
    localparam logic [NA-1:0] VY [NV] = '{8'sd5, 8'sd5, -8'sd5, -8'sd5, -8'sd128, -8'sd128, -8'sd1,
                                         -8'sd128, 8'sd127, 8'sd127, 8'sd16, -8'sd16, -8'sd128, 8'sd127};
    localparam int VP [NV] = '{15, -15, -15, 15, 0, 16384, 1,
                               -16256, 16129, -16256, 256, 256, -2048, -2032};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst, start_a, start_b;
    logic [NA-1:0]  xa, ya;
    logic [NB-1:0]  xb, yb;
    logic [2*NA-1:0] pa;
    logic [2*NB-1:0] pb;
    logic           da, db;

    mul_signed_seq #(.N(NA)) u_mul_signed_seq (
        .clk(clk), .rst(rst), .start(start_a), .x_in(xa), .y_in(ya), .product(pa), .done(da));

    mul_signed_seq #(.N(NB)) u_wide (
        .clk(clk), .rst(rst), .start(start_b), .x_in(xb), .y_in(yb), .product(pb), .done(db));

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    task automatic chk(input string req, input longint act, input longint expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_a(input logic [NA-1:0] x, input logic [NA-1:0] y,
                         input longint expv, input string req);
        @(negedge clk);
        start_a = 1'b1; xa = x; ya = y;
        @(negedge clk);
        start_a = 1'b0;
        chk("R2 done low after start", longint'(da), 0);
        repeat (NA - 1) @(negedge clk);
        chk("R3 done still low after N-1 edges", longint'(da), 0);
        @(negedge clk);
        chk("R3 done high after N edges", longint'(da), 1);
        chk(req, longint'($signed(pa)), expv);
    endtask

    task automatic run_b(input logic [NB-1:0] x, input logic [NB-1:0] y, input string req);
        longint expv;
        expv = longint'($signed(x)) * longint'($signed(y));
        @(negedge clk);
        start_b = 1'b1; xb = x; yb = y;
        @(negedge clk);
        start_b = 1'b0;
        repeat (NB - 1) @(negedge clk);
        chk("R3 wide done still low", longint'(db), 0);
        @(negedge clk);
        chk("R3 wide done high", longint'(db), 1);
        chk(req, longint'($signed(pb)), expv);
    endtask

    initial begin
        rst = 1'b1; start_a = 1'b0; start_b = 1'b0;
        xa = '0; ya = '0; xb = '0; yb = '0;
        repeat (2) @(negedge clk);
        chk("R1 reset done", longint'(da), 0);
        chk("R1 reset product", longint'(pa), 0);
        chk("R1 reset wide done", longint'(db), 0);
        rst = 1'b0;

        // R4 R5 R6: table of operands and expected products
        for (int i = 0; i < NV; i++) begin
            run_a(VX[i], VY[i], longint'(VP[i]), "R4 R5 R6 table product");
        end

        // R10 wide corners
        run_b(32'h8000_0000, 32'h8000_0000, "R10 R5 min squared");
        run_b(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 R5 minus one squared");
        run_b(32'h7FFF_FFFF, 32'h8000_0000, "R10 R5 max times min");
        run_b(32'h0001_0000, 32'h0001_0000, "R10 half powers");
        run_b(32'hFFFF_0000, 32'h7FFF_FFFF, "R10 R6 negative multiplier");

        // R8: start and operand changes mid-run ignored
        @(negedge clk);
        start_a = 1'b1; xa = 8'sd5; ya = 8'sd7;
        @(negedge clk);
        start_a = 1'b0;
        @(negedge clk);
        start_a = 1'b1; xa = 8'sd100; ya = -8'sd3;
        @(negedge clk);
        start_a = 1'b0; xa = -8'sd9; ya = 8'sd11;
        repeat (NA - 3) @(negedge clk);
        chk("R8 done low before N edges", longint'(da), 0);
        @(negedge clk);
        chk("R8 done after N edges", longint'(da), 1);
        chk("R8 product of captured operands", longint'($signed(pa)), 35);

        // R7: hold while idle with changing inputs
        xa = 8'sd1; ya = 8'sd1;
        repeat (5) @(negedge clk);
        xa = -8'sd2;
        repeat (3) @(negedge clk);
        chk("R7 done held", longint'(da), 1);
        chk("R7 product held", longint'($signed(pa)), 35);

        // R1: reset in mid-operation
        @(negedge clk);
        start_a = 1'b1; xa = 8'sd9; ya = 8'sd9;
        @(negedge clk);
        start_a = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-run reset done", longint'(da), 0);
        chk("R1 mid-run reset product", longint'(pa), 0);
        repeat (2 * NA) @(negedge clk);
        chk("R1 no completion after reset", longint'(da), 0);

        // R2 R4 after the reset, block is usable again
        run_a(-8'sd7, 8'sd6, -42, "R4 product after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule